// File: doc/BRIEF.md
# DMA Channel Byte Counter with Status Word

This block keeps the remaining byte count and the status flags of one DMA channel. Both live in a single register word. A CPU bus interface reads that word and writes it through one strobe. The count sits in the low 24 bits and the status flags in the top 8 bits.

A start request validates the programmed count against the requested access size. It then either arms the channel, flags a configuration error, or reports completion straight away when the count is zero. While the channel is armed, the datapath sends a pulse each time the address phase of a write completes. On each pulse the count drops by the access size, and completion is flagged when the count reaches zero.

Software acknowledges completion by writing a one to the done bit. That write clears the whole status byte.

Top module: `dma_count_status`

## Requirements
- R1: After a synchronous active-low reset, the count and every status bit read as zero and `xfer_en` is low.
- R2: `reg_rdata` carries the count in bits 23:0 and the status byte in bits 31:24. Within the status byte, bit 24 is done, bit 25 is busy and bit 26 is configuration error, and bits 31:27 always read zero.
- R3: The access size is encoded 00 byte, 01 word, 10 longword, 11 line, and it is captured when a start is accepted. While busy, each `wr_addr_done` pulse lowers the count by 1, 2, 4 or 16 for that captured size.
- R4: When a pulse brings the count to zero (or would take it below zero), the count becomes zero, done is set and busy is cleared, all at the same clock edge.
- R5: A start whose nonzero count is not a multiple of the size step (2 for word, 4 for longword, 16 for line) sets the configuration error bit and leaves busy and `xfer_en` low.
- R6: A start with a zero count sets done at once and never raises busy or `xfer_en`.
- R7: A register write with bit 24 set clears done, busy and configuration error. A register write with bit 24 clear leaves the status byte unchanged, whatever it carries in bits 31:25.
- R8: Every register write loads bits 23:0 into the count. In that same cycle, any start or `wr_addr_done` is ignored.
- R9: A start that arrives while busy is ignored.
- R10: A `wr_addr_done` pulse that arrives while not busy leaves the count unchanged.
- R11: An accepted start with a valid nonzero count sets busy and clears done and configuration error. `xfer_en` is high exactly while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | CPU write strobe for the count/status word |
| reg_wdata | input | 32 | CPU write data |
| reg_rdata | output | 32 | Count and status word, read back |
| start | input | 1 | Request to begin a block transfer |
| xfer_size | input | 2 | Access size for the next start |
| wr_addr_done | input | 1 | Pulse when a write address phase completes |
| xfer_en | output | 1 | Channel may move data |
| done | output | 1 | Block transfer finished |
| cfg_err | output | 1 | Count misaligned to the access size |

## Verification
The assertions assume two things about the inputs. First, a register write is the only way the count changes outside an active transfer. Second, the datapath's completion pulse is a single-cycle level that can be sampled at the clock edge. The bench drives every input one full cycle at a time from the falling edge, so no pulse is narrower than a clock and none straddles an edge.

The random phase mixes writes, starts and pulses in any combination, including writes that coincide with starts or pulses and starts during busy. The behavioural model resolves these by the precedence that R8 and R9 state.

// File: rtl/dsc_pkg.sv
// Package: shared types and status bit positions for the DMA count/status block.
// Assumes: status bits are indexed from the bottom of the status byte.
package dsc_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_WORD = 2'b01,
        SZ_LONG = 2'b10,
        SZ_LINE = 2'b11
    } xfer_size_e;

    localparam int ST_DONE   = 0;
    localparam int ST_BUSY   = 1;
    localparam int ST_CFGERR = 2;
endpackage

// File: rtl/dsc_size_step.sv
// Module: turns an access size code into its byte step and flags a count that
// is not a whole number of steps.
// Assumes: CNT_W >= 5 so a 16-byte step fits.
module dsc_size_step #(
    parameter int CNT_W = 24
) (
    input  logic [1:0]       size,
    input  logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] step,
    output logic             misaligned
);
    import dsc_pkg::*;

    // Map the size code onto its step in bytes.
    always_comb begin
        case (xfer_size_e'(size))
            SZ_BYTE: step = CNT_W'(1);
            SZ_WORD: step = CNT_W'(2);
            SZ_LONG: step = CNT_W'(4);
            default: step = CNT_W'(16);
        endcase
    end

    // Any set bit below the step's power of two means a partial last access.
    always_comb misaligned = |(count & (step - CNT_W'(1)));
endmodule

// File: rtl/dsc_counter.sv
// Module: remaining-byte counter. Loads from the CPU and steps down on
// qualified write completions, stopping at zero.
// Assumes: load and dec_en are never high together (the top gives load priority).
module dsc_counter #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec_en,
    input  logic [CNT_W-1:0] step,
    output logic [CNT_W-1:0] count,
    output logic             last_beat
);
    // A qualified completion that empties the count ends the block.
    always_comb last_beat = dec_en && (count <= step);

    // Count register: CPU load first, then a decrement that stops at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (load)
            count <= load_val;
        else if (dec_en)
            count <= (count <= step) ? '0 : count - step;
    end

    assert_dec_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_en && !load && count > step) |=> (count == $past(count) - $past(step)));

    assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!dec_en && !load) |=> $stable(count));

    assert_zero_at_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (last_beat && !load) |=> (count == '0));
endmodule

// File: rtl/dsc_status.sv
// Module: channel status flags (done, busy, configuration error) and the access
// size captured at an accepted start.
// Assumes: cpu_wr wins over start and last_beat in the same cycle; last_beat is
// only high while busy.
module dsc_status (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cpu_wr,
    input  logic       cpu_clr,
    input  logic       start,
    input  logic [1:0] size_in,
    input  logic       count_zero,
    input  logic       misaligned,
    input  logic       last_beat,
    output logic       done_q,
    output logic       busy_q,
    output logic       cfg_err_q,
    output logic [1:0] size_q
);
    logic start_ok;

    // A start counts only when the channel is idle and no CPU write competes.
    always_comb start_ok = start && !cpu_wr && !busy_q;

    // Status flags: CPU clear, then start outcome, then end of block.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q    <= 1'b0;
            busy_q    <= 1'b0;
            cfg_err_q <= 1'b0;
        end else if (cpu_wr) begin
            if (cpu_clr) begin
                done_q    <= 1'b0;
                busy_q    <= 1'b0;
                cfg_err_q <= 1'b0;
            end
        end else if (start_ok) begin
            if (count_zero) begin
                done_q    <= 1'b1;
                cfg_err_q <= 1'b0;
            end else if (misaligned) begin
                done_q    <= 1'b0;
                cfg_err_q <= 1'b1;
            end else begin
                done_q    <= 1'b0;
                cfg_err_q <= 1'b0;
                busy_q    <= 1'b1;
            end
        end else if (last_beat) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
        end
    end

    // Size capture: holds the step size for the whole active block.
    always_ff @(posedge clk) begin
        if (!rst_n)
            size_q <= 2'b00;
        else if (start_ok && !count_zero && !misaligned)
            size_q <= size_in;
    end

    assert_busy_done_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_q && done_q));

    assert_done_after_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (last_beat && !cpu_wr) |=> (done_q && !busy_q));

    assert_err_blocks_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err_q |-> !busy_q);

    assert_clear_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_clr) |=> (!done_q && !busy_q && !cfg_err_q));

    assert_keep_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && !cpu_clr) |=> ($stable(done_q) && $stable(busy_q) && $stable(cfg_err_q)));

    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && start && !cpu_wr && !last_beat) |=> (busy_q && $stable(size_q)));
endmodule

// File: rtl/dma_count_status.sv
// Module: top of the per-channel byte count and status logic. Packs the status
// byte above the count into one CPU-visible word and joins the counter, size
// check and status flags.
// Assumes: wr_addr_done is a one-cycle pulse per completed write address phase.
module dma_count_status #(
    parameter  int CNT_W  = 24,
    parameter  int STAT_W = 8,
    localparam int REG_W  = CNT_W + STAT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             start,
    input  logic [1:0]       xfer_size,
    input  logic             wr_addr_done,
    output logic             xfer_en,
    output logic             done,
    output logic             cfg_err
);
    import dsc_pkg::*;

    localparam int DONE_BIT = CNT_W + ST_DONE;

    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] start_step;
    logic [CNT_W-1:0] run_step;
    logic             start_misaligned;
    logic             run_misaligned;
    logic             dec_en;
    logic             last_beat;
    logic             busy;
    logic [1:0]       size_q;
    logic [STAT_W-1:0] status;

    // Decrements only while busy and never in a CPU write cycle.
    always_comb dec_en = busy && wr_addr_done && !reg_wr;

    // Size check against the requested size, used at start.
    dsc_size_step #(.CNT_W(CNT_W)) i_start_chk (
        .size       (xfer_size),
        .count      (count),
        .step       (start_step),
        .misaligned (start_misaligned)
    );

    // Step for the size captured at start, used while running.
    dsc_size_step #(.CNT_W(CNT_W)) i_run_step (
        .size       (size_q),
        .count      (count),
        .step       (run_step),
        .misaligned (run_misaligned)
    );

    dsc_counter #(.CNT_W(CNT_W)) i_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (reg_wr),
        .load_val  (reg_wdata[CNT_W-1:0]),
        .dec_en    (dec_en),
        .step      (run_step),
        .count     (count),
        .last_beat (last_beat)
    );

    dsc_status i_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_wr     (reg_wr),
        .cpu_clr    (reg_wdata[DONE_BIT]),
        .start      (start),
        .size_in    (xfer_size),
        .count_zero (count == '0),
        .misaligned (start_misaligned),
        .last_beat  (last_beat),
        .done_q     (done),
        .busy_q     (busy),
        .cfg_err_q  (cfg_err),
        .size_q     (size_q)
    );

    // Status byte layout: flags at the bottom, unused upper bits read zero.
    always_comb begin
        status            = '0;
        status[ST_DONE]   = done;
        status[ST_BUSY]   = busy;
        status[ST_CFGERR] = cfg_err;
    end

    // Read word and transfer enable.
    always_comb reg_rdata = {status, count};
    always_comb xfer_en   = busy;

    assert_err_no_xfer_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !xfer_en);

    assert_zero_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !reg_wr && count == '0) |=> (done && !xfer_en));

    assert_run_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $rose(busy)) |-> !run_misaligned);
endmodule

// File: tb/test_dma_count_status.sv
module test_dma_count_status;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        start;
    logic [1:0]  xfer_size;
    logic        wr_addr_done;
    logic        xfer_en;
    logic        done;
    logic        cfg_err;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    string cur_req = "R1";

    // behavioural reference state
    int unsigned m_count;
    bit m_done, m_busy, m_err;
    int m_size;

    dma_count_status i_dma_count_status (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .start(start), .xfer_size(xfer_size),
        .wr_addr_done(wr_addr_done), .xfer_en(xfer_en), .done(done), .cfg_err(cfg_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int step_of(int sz);
        case (sz)
            0: return 1;
            1: return 2;
            2: return 4;
            default: return 16;
        endcase
    endfunction

    function automatic logic [31:0] model_word();
        return {5'b0, m_err, m_busy, m_done, m_count[23:0]};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h (t=%0t)", req, act, exp, $time);
        end
    endtask

    // reference update on every rising edge
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_count = 0; m_done = 0; m_busy = 0; m_err = 0; m_size = 0;
        end else if (reg_wr) begin
            m_count = reg_wdata[23:0];
            if (reg_wdata[24]) begin m_done = 0; m_busy = 0; m_err = 0; end
        end else if (start && !m_busy) begin
            if (m_count == 0) begin m_done = 1; m_err = 0; end
            else if (m_count % step_of(xfer_size) != 0) begin m_err = 1; m_done = 0; end
            else begin m_busy = 1; m_done = 0; m_err = 0; m_size = xfer_size; end
        end else if (m_busy && wr_addr_done) begin
            if (m_count <= step_of(m_size)) begin m_count = 0; m_busy = 0; m_done = 1; end
            else m_count = m_count - step_of(m_size);
        end
    end

    // compare on every falling edge once out of reset
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            check({cur_req, "/R2 word"}, reg_rdata, model_word());
            check("R11 xfer_en", {31'b0, xfer_en}, {31'b0, m_busy});
            check({cur_req, " flags"}, {30'b0, done, cfg_err}, {30'b0, m_done, m_err});
        end
    end

    always @(posedge clk) begin
        if (cycles > WATCHDOG) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog: actual %0d expected <= %0d cycles", cycles, WATCHDOG);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic idle();
        reg_wr = 0; reg_wdata = '0; start = 0; wr_addr_done = 0;
    endtask

    task automatic step_cyc(bit w, logic [31:0] wd, bit st, logic [1:0] sz, bit p);
        @(negedge clk);
        reg_wr = w; reg_wdata = wd; start = st; xfer_size = sz; wr_addr_done = p;
        @(negedge clk);
        idle();
    endtask

    initial begin
        idle(); xfer_size = 0; rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1 reset word", reg_rdata, 32'h0);
        check("R1 reset enable", {31'b0, xfer_en}, 32'h0);

        // line transfer of 64 bytes
        cur_req = "R3";
        step_cyc(1, 32'd64, 0, 0, 0);
        step_cyc(0, 0, 1, 2'b11, 0);
        check("R11 busy after start", reg_rdata, 32'h0200_0040);
        step_cyc(0, 0, 0, 0, 1);
        check("R3 line step", reg_rdata, 32'h0200_0030);
        step_cyc(0, 0, 1, 2'b00, 0);
        check("R9 start while busy", reg_rdata, 32'h0200_0030);
        cur_req = "R4";
        repeat (3) step_cyc(0, 0, 0, 0, 1);
        check("R4 done at zero", reg_rdata, 32'h0100_0000);

        // write without done bit, with other status bits set
        cur_req = "R7";
        step_cyc(1, 32'hFE00_0008, 0, 0, 0);
        check("R7 status kept, R8 count loaded", reg_rdata, 32'h0100_0008);
        step_cyc(1, 32'h0100_0006, 0, 0, 0);
        check("R7 done cleared", reg_rdata, 32'h0000_0006);

        // misaligned longword start
        cur_req = "R5";
        step_cyc(0, 0, 1, 2'b10, 0);
        check("R5 cfg error", reg_rdata, 32'h0400_0006);
        cur_req = "R10";
        step_cyc(0, 0, 0, 0, 1);
        check("R10 idle pulse", reg_rdata, 32'h0400_0006);
        step_cyc(1, 32'h0100_000A, 0, 0, 0);
        check("R7 err cleared", reg_rdata, 32'h0000_000A);

        // word transfer of 10 bytes, restarted-start ignored
        cur_req = "R11";
        step_cyc(0, 0, 1, 2'b01, 0);
        check("R11 word start", reg_rdata, 32'h0200_000A);
        step_cyc(0, 0, 1, 2'b11, 1);
        check("R9 start+pulse while busy", reg_rdata, 32'h0200_0008);
        repeat (4) step_cyc(0, 0, 0, 0, 1);
        check("R4 word done", reg_rdata, 32'h0100_0000);

        // zero count start
        cur_req = "R6";
        step_cyc(1, 32'h0100_0000, 0, 0, 0);
        step_cyc(0, 0, 1, 2'b00, 0);
        check("R6 zero start", reg_rdata, 32'h0100_0000);
        check("R6 no enable", {31'b0, xfer_en}, 32'h0);

        // write coinciding with start
        cur_req = "R8";
        step_cyc(1, 32'h0100_0003, 1, 2'b00, 0);
        check("R8 start ignored on write", reg_rdata, 32'h0000_0003);
        step_cyc(0, 0, 1, 2'b00, 0);
        step_cyc(1, 32'h0000_0005, 0, 0, 1);
        check("R8 pulse ignored on write", reg_rdata, 32'h0200_0005);
        step_cyc(1, 32'h0100_0000, 0, 0, 0);
        check("R7 abort clears busy", reg_rdata, 32'h0000_0000);

        // random mix against the reference model
        cur_req = "R3/R4/R5/R9";
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            reg_wr       = ($urandom % 100) < 6;
            reg_wdata    = {7'($urandom), 1'($urandom % 2), 16'h0, 8'($urandom % 80)};
            start        = ($urandom % 100) < 15;
            xfer_size    = 2'($urandom);
            wr_addr_done = ($urandom % 100) < 45;
        end
        @(negedge clk);
        idle();
        @(negedge clk);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule